// File: doc/BRIEF.md
# UART Status and Error Capture Register

This block is the status word of a UART as software sees it. It samples the live conditions of the transmit and receive paths (busy, break, FIFO levels, done flags) into one 32-bit word. It also brings the asynchronous clear-to-send input into the clock domain and reports both its level and a change of that level. Protocol errors arrive as single-cycle pulses. The first one is kept as a sticky flag together with a 4-bit cause code, and any later error is ignored until software clears the flag.

Each of the ten low status bits can also serve as an interrupt source. For each of them the block produces a one-cycle request pulse when the bit goes from 0 to 1. A bit that stays high produces no further requests. A mask register downstream decides which requests are used. Software reads the word from `status_o`. It writes through a single write strobe, and only the write-one-to-clear bits respond to a write.

Top module: `uart_stat_reg`

## Requirements
- R1: While reset is asserted and right after it ends, `status_o` equals 0x0F000030 and `irq_o` is 0. That value means: error flag clear, code 15, bits 5 and 4 set, all other bits 0.
- R2: The levels `busy_i`, `break_i`, `tx_half_i`, `tx_space_i`, `tx_done_i`, `rx_half_i`, `rx_data_i` and `rx_done_i` appear one clock later at bits 28, 8, 5, 4, 3, 2, 1 and 0 respectively. Bits 28 and 8 follow their input in both directions.
- R3: An error pulse while no error is held sets bit 9 on the next clock. The code at bits 27:24 is then 0 for a missing stop bit, 1 for a parity mismatch, 12 for a write to a full TX FIFO, 13 for a read from an empty RX FIFO and 14 for an RX overflow.
- R4: When several error pulses arrive in the same cycle and no error is held, the lowest-numbered code is stored.
- R5: While bit 9 is set and not being cleared, later error pulses change neither bit 9 nor bits 27:24.
- R6: A write with bit 9 of `wr_data_i` high clears bit 9 and returns the code to 15. A write with bit 9 low leaves bit 9 and the code unchanged.
- R7: If the clear of bit 9 and a new error pulse fall in the same cycle, the new error is held with its own code.
- R8: `cts_i` passes through a two-flop synchronizer. Its level shows at bit 6 two clocks after it changes. Bit 7 is set the clock after bit 6 changes, and it stays set until a write with `wr_data_i` bit 7 high. If a new change and such a write fall in the same cycle, the change wins and bit 7 stays set.
- R9: `irq_o[k]` is high for exactly one cycle in the cycle where status bit k (k = 0..9) has just gone from 0 to 1. It stays low while the bit is held high.
- R10: Bits 31:29 and 23:10 read as 0. Writing 1 to any bit other than 9 and 7 has no effect on the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_stop_i | input | 1 | Pulse: missing stop bit |
| err_parity_i | input | 1 | Pulse: received parity mismatch |
| err_txfull_i | input | 1 | Pulse: write to full TX FIFO |
| err_rxempty_i | input | 1 | Pulse: read from empty RX FIFO |
| err_rxovf_i | input | 1 | Pulse: RX FIFO overflow |
| busy_i | input | 1 | Transmitter busy level |
| break_i | input | 1 | Break detect level |
| cts_i | input | 1 | Clear-to-send, asynchronous |
| tx_half_i | input | 1 | TX FIFO at most half full |
| tx_space_i | input | 1 | TX FIFO has space |
| tx_done_i | input | 1 | Transmission finished |
| rx_half_i | input | 1 | RX FIFO at least half full |
| rx_data_i | input | 1 | RX FIFO holds data |
| rx_done_i | input | 1 | Reception finished |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| status_o | output | 32 | Status word |
| irq_o | output | 10 | Rising-edge interrupt requests for bits 9:0 |

## Verification
The properties assume that the error inputs are clean synchronous signals. They also assume that the write strobe is the only path by which software changes the word. With these assumptions, a held error can only leave bit 9 through a write that clears it, and the error code can only move when the flag is clear or being cleared. The stimulus changes every input at the falling edge and keeps each error pulse and each write to a single cycle. It raises `cts_i` only between rising edges, so the synchronizer never sees an input change at its sampling edge.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int unsigned STAT_W   = 32;
  localparam int unsigned BIT_BUSY = 28;
  localparam int unsigned CODE_LSB = 24;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned BIT_ERR  = 9;
  localparam int unsigned BIT_BRK  = 8;
  localparam int unsigned BIT_CTOG = 7;
  localparam int unsigned BIT_CTS  = 6;
  localparam int unsigned LVL_W    = 6;
  localparam int unsigned IRQ_W    = 10;
  localparam int unsigned NUM_ERR  = 5;

  localparam logic [LVL_W-1:0]  LVL_RST  = 6'b110000;
  localparam logic [STAT_W-1:0] STAT_RST = 32'h0F00_0030;

  typedef enum logic [CODE_W-1:0] {
    ERR_STOP    = 4'd0,
    ERR_PARITY  = 4'd1,
    ERR_TXFULL  = 4'd12,
    ERR_RXEMPTY = 4'd13,
    ERR_RXOVF   = 4'd14,
    ERR_NONE    = 4'd15
  } err_code_e;

  // index in the pulse vector is also the priority (0 highest)
  function automatic err_code_e code_of(input int unsigned idx);
    case (idx)
      0:       return ERR_STOP;
      1:       return ERR_PARITY;
      2:       return ERR_TXFULL;
      3:       return ERR_RXEMPTY;
      default: return ERR_RXOVF;
    endcase
  endfunction
endpackage

// File: rtl/uart_stat_cts.sv
module uart_stat_cts #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_i,
  output logic level_o,
  output logic change_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pipe_q[i] <= 1'b0;
          else         pipe_q[i] <= cts_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pipe_q[i] <= 1'b0;
          else         pipe_q[i] <= pipe_q[i-1];
        end
      end
    end
  endgenerate

  assign level_o  = pipe_q[STAGES-1];
  assign change_o = pipe_q[STAGES-1] ^ pipe_q[STAGES];
endmodule

// File: rtl/uart_stat_err.sv
module uart_stat_err
  import uart_stat_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] pulse_i,
  input  logic               clr_i,
  output logic               err_o,
  output logic [CODE_W-1:0]  code_o
);
  logic              err_q, err_d;
  err_code_e         code_q, code_d, first_code;
  logic              any_err;

  assign any_err = |pulse_i;

  always_comb begin
    first_code = ERR_NONE;
    for (int i = NUM_ERR - 1; i >= 0; i--) begin
      if (pulse_i[i]) first_code = code_of(i);
    end
  end

  always_comb begin
    err_d  = err_q;
    code_d = code_q;
    if (err_q && !clr_i) begin
      err_d  = err_q;
      code_d = code_q;
    end else if (any_err) begin
      err_d  = 1'b1;
      code_d = first_code;
    end else if (clr_i) begin
      err_d  = 1'b0;
      code_d = ERR_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
    end else begin
      err_q  <= err_d;
      code_q <= code_d;
    end
  end

  assign err_o  = err_q;
  assign code_o = code_q;
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq #(
  parameter int unsigned       W       = 10,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] irq_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= src_i;
  end

  assign irq_o = src_i & ~prev_q;
endmodule

// File: rtl/uart_stat_reg.sv
module uart_stat_reg
  import uart_stat_pkg::*;
#(
  parameter int unsigned CTS_SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_stop_i,
  input  logic              err_parity_i,
  input  logic              err_txfull_i,
  input  logic              err_rxempty_i,
  input  logic              err_rxovf_i,
  input  logic              busy_i,
  input  logic              break_i,
  input  logic              cts_i,
  input  logic              tx_half_i,
  input  logic              tx_space_i,
  input  logic              tx_done_i,
  input  logic              rx_half_i,
  input  logic              rx_data_i,
  input  logic              rx_done_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic [IRQ_W-1:0]  irq_o
);
  logic               busy_q, brk_q, ctog_q;
  logic [LVL_W-1:0]   lvl_q;
  logic               cts_lvl, cts_chg;
  logic               err_flag;
  logic [CODE_W-1:0]  err_code;
  logic               clr_err, clr_ctog;
  logic [STAT_W-1:0]  stat;
  logic               unused_wr;

  assign clr_err   = wr_en_i & wr_data_i[BIT_ERR];
  assign clr_ctog  = wr_en_i & wr_data_i[BIT_CTOG];
  assign unused_wr = ^{wr_data_i[STAT_W-1:BIT_ERR+1], wr_data_i[BIT_BRK],
                       wr_data_i[BIT_CTS:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      brk_q  <= 1'b0;
      lvl_q  <= LVL_RST;
    end else begin
      busy_q <= busy_i;
      brk_q  <= break_i;
      lvl_q  <= {tx_half_i, tx_space_i, tx_done_i, rx_half_i, rx_data_i, rx_done_i};
    end
  end

  uart_stat_cts #(.STAGES(CTS_SYNC_STAGES)) u_cts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cts_i    (cts_i),
    .level_o  (cts_lvl),
    .change_o (cts_chg)
  );

  // a fresh change beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctog_q <= 1'b0;
    else if (cts_chg)  ctog_q <= 1'b1;
    else if (clr_ctog) ctog_q <= 1'b0;
  end

  uart_stat_err u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i ({err_rxovf_i, err_rxempty_i, err_txfull_i, err_parity_i, err_stop_i}),
    .clr_i   (clr_err),
    .err_o   (err_flag),
    .code_o  (err_code)
  );

  always_comb begin
    stat                        = '0;
    stat[BIT_BUSY]              = busy_q;
    stat[CODE_LSB +: CODE_W]    = err_code;
    stat[BIT_ERR]               = err_flag;
    stat[BIT_BRK]               = brk_q;
    stat[BIT_CTOG]              = ctog_q;
    stat[BIT_CTS]               = cts_lvl;
    stat[LVL_W-1:0]             = lvl_q;
  end

  assign status_o = stat;

  uart_stat_irq #(.W(IRQ_W), .RST_VAL(STAT_RST[IRQ_W-1:0])) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (stat[IRQ_W-1:0]),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/uart_stat_chk.sv
module uart_stat_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        err_stop_i,
  input logic        err_parity_i,
  input logic        err_txfull_i,
  input logic        err_rxempty_i,
  input logic        err_rxovf_i,
  input logic        busy_i,
  input logic        break_i,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] status_o,
  input logic [9:0]  irq_o
);
  logic any_err;
  assign any_err = err_stop_i | err_parity_i | err_txfull_i | err_rxempty_i | err_rxovf_i;

  // R5
  sticky_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[9] && !(wr_en_i && wr_data_i[9]) |=> status_o[9] && $stable(status_o[27:24]));

  // R3
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_err |=> status_o[9]);

  // R6
  idle_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[9] |-> status_o[27:24] == 4'hF);

  // R2
  busy_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_o[28] == $past(busy_i) && status_o[8] == $past(break_i));

  // R9
  irq_src_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~status_o[9:0]) == 10'd0);

  // R9
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |irq_o |=> (irq_o & $past(irq_o)) == 10'd0);

  // R10
  zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[31:29] == 3'd0 && status_o[23:10] == 14'd0);
endmodule

bind uart_stat_reg uart_stat_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .err_stop_i    (err_stop_i),
  .err_parity_i  (err_parity_i),
  .err_txfull_i  (err_txfull_i),
  .err_rxempty_i (err_rxempty_i),
  .err_rxovf_i   (err_rxovf_i),
  .busy_i        (busy_i),
  .break_i       (break_i),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .status_o      (status_o),
  .irq_o         (irq_o)
);

// File: tb/tb_uart_stat_reg.sv
`timescale 1ns/1ps
module tb_uart_stat_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic e_stop = 0, e_par = 0, e_txf = 0, e_rxe = 0, e_ovf = 0;
  logic busy = 0, brk = 0, cts = 0;
  logic txh = 1, txs = 1, txd = 0, rxh = 0, rxd = 0, rxdn = 0;
  logic wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] status;
  logic [9:0]  irq;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  uart_stat_reg dut (
    .clk_i(clk), .rst_ni(rst_n),
    .err_stop_i(e_stop), .err_parity_i(e_par), .err_txfull_i(e_txf),
    .err_rxempty_i(e_rxe), .err_rxovf_i(e_ovf),
    .busy_i(busy), .break_i(brk), .cts_i(cts),
    .tx_half_i(txh), .tx_space_i(txs), .tx_done_i(txd),
    .rx_half_i(rxh), .rx_data_i(rxd), .rx_done_i(rxdn),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .status_o(status), .irq_o(irq)
  );

  // scoreboard queues
  string       tag_q[$];
  logic [31:0] st_q[$];
  logic [9:0]  irq_q[$];

  // reference state built from the requirements
  logic        m_err = 0;
  logic [3:0]  m_code = 4'hF;
  logic [2:0]  m_c = 3'b000;
  logic        m_tog = 0;
  logic [31:0] m_stat = 32'h0F00_0030;

  task automatic check(string tag, logic [31:0] st_e, logic [9:0] irq_e);
    n_chk++;
    if (status !== st_e || irq !== irq_e) begin
      n_fail++;
      $display("FAIL %s status=%h irq=%b expected status=%h irq=%b", tag, status, irq, st_e, irq_e);
    end
  endtask

  task automatic step(string tag);
    logic       clr, tclr, tog_now;
    logic [31:0] nxt;
    clr  = wr_en & wr_data[9];
    tclr = wr_en & wr_data[7];
    if (!(m_err && !clr)) begin
      if (e_stop | e_par | e_txf | e_rxe | e_ovf) begin
        m_err  = 1'b1;
        m_code = e_stop ? 4'd0 : e_par ? 4'd1 : e_txf ? 4'd12 : e_rxe ? 4'd13 : 4'd14;
      end else if (clr) begin
        m_err  = 1'b0;
        m_code = 4'hF;
      end
    end
    tog_now = m_c[1] ^ m_c[2];
    m_tog   = tog_now | (m_tog & ~tclr);
    m_c     = {m_c[1:0], cts};
    nxt = {3'b0, busy, m_code, 14'b0, m_err, brk, m_tog, m_c[1], txh, txs, txd, rxh, rxd, rxdn};
    tag_q.push_back(tag);
    st_q.push_back(nxt);
    irq_q.push_back(nxt[9:0] & ~m_stat[9:0]);
    m_stat = nxt;
    @(posedge clk);
    @(negedge clk);
    {e_stop, e_par, e_txf, e_rxe, e_ovf} = '0;
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  always @(posedge clk) begin
    #1;
    if (tag_q.size() > 0) check(tag_q.pop_front(), st_q.pop_front(), irq_q.pop_front());
  end

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 32'h0F00_0030, 10'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 32'h0F00_0030, 10'd0);
    step("R1 idle");

    // level patterns
    busy = 1; rxdn = 1; step("R2 busy rx_done");
    step("R9 held no repeat");
    txh = 0; txs = 0; txd = 1; rxd = 1; rxh = 1; step("R2 fifo levels");
    txh = 1; step("R9 tx_half rise");
    brk = 1; busy = 0; step("R2 break set busy drop");
    brk = 0; step("R2 break follows");
    rxdn = 0; rxd = 0; rxh = 0; txd = 0; txs = 1; step("R2 restore");

    // single errors
    e_par = 1; step("R3 parity code 1");
    step("R9 err held");
    e_stop = 1; step("R5 later error ignored");
    e_ovf = 1; step("R5 later ovf ignored");
    wr(32'hFFFF_FDFF); step("R6 write zero to bit9, R10 other bits");
    wr(32'h0000_0200); step("R6 clear");
    e_stop = 1; step("R3 stop code 0");
    wr(32'h0000_0200); step("R6 clear");
    e_txf = 1; step("R3 txfull code 12");
    wr(32'h0000_0200); step("R6 clear");
    e_rxe = 1; step("R3 rxempty code 13");
    wr(32'h0000_0200); step("R6 clear");
    e_ovf = 1; step("R3 ovf code 14");
    wr(32'h0000_0200); step("R6 clear");

    // simultaneous
    e_txf = 1; e_rxe = 1; e_ovf = 1; step("R4 lowest of 12,13,14");
    wr(32'h0000_0200); step("R6 clear");
    e_par = 1; e_ovf = 1; e_rxe = 1; step("R4 parity wins");
    wr(32'h0000_0200); e_stop = 1; step("R7 clear with new error");
    wr(32'h0000_0200); e_txf = 1; step("R7 again");
    wr(32'h0000_0200); step("R6 clear");

    // CTS
    cts = 1; step("R8 sync 1");
    step("R8 level");
    step("R8 toggle set");
    step("R8 toggle held");
    wr(32'h0000_0080); step("R8 toggle clear");
    step("R8 stays clear");
    cts = 0; step("R8 fall sync");
    step("R8 level low");
    wr(32'h0000_0080); step("R8 change beats clear");
    step("R8 held");
    wr(32'h0000_0080); step("R8 clear");
    step("R9 idle");
    repeat (3) step("R10 quiet");

    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule